// File: doc/BRIEF.md
# Self-describing IP information register bank

This block is a small memory-mapped slave placed next to an IP block on the system interconnect. It answers a fixed window of 32-bit, word-addressed registers that let software find the IP by scanning the address space and then identify it. The window opens with a discovery word that changes on every read of it. Next come a capability word, a pointer to the parent's own registers, a software reset for the parent, an instance number and a mutex for systems with several bus masters. After those sit packed identification strings and an extra-information string.

The bus port is a single-cycle request: a request is taken on the clock edge where `req_valid` is high, and read data returns, registered, in the following cycle. The software reset is a register bit that drives the parent's active-high reset. A build-time capability flag can disable it. The mutex records the ID of the master that holds it.

Top module: `iinfo_bank`

## Requirements
- R1: Synchronous reset (`rst` high) clears `rd_valid`, `parent_rst` and the mutex owner to 0, and returns the discovery word to its first phase.
- R2: A read accepted at a clock edge sets `rd_valid` and the data on `rd_data` after that same edge, for one cycle only. Back-to-back reads give back-to-back results. When no read is accepted, `rd_valid` is 0 and `rd_data` is zero.
- R3: Word 0 is read-only. Its first read after reset returns 32'h49495231 (ASCII "IIR1", first character in bits 31:24). The next read returns 32'h31524949, and the two values alternate from then on. Writes to word 0 and reads of other words do not advance it.
- R4: Word 1 reads {29'b0, CAN_RESET, HAS_REGS, IS_EXTERNAL}: bit 0 means the bank is external, bit 1 means the parent has bus registers, bit 2 means the parent can be reset.
- R5: Word 2 reads PARENT_OFS when the bank is internal and PARENT_ADDR when it is external. It reads zero when HAS_REGS is 0.
- R6: When CAN_RESET is 1, a write to word 3 loads bit 0 of the write data. That bit drives `parent_rst` from the next cycle and reads back in bit 0 of word 3.
- R7: When CAN_RESET is 0, writes to word 3 are ignored, word 3 reads zero and `parent_rst` stays 0.
- R8: Word 4 reads the INSTANCE_NUM parameter.
- R9: Word 5 reads the mutex owner ID. A write of a nonzero value (low IDW bits) takes the mutex only while the owner is 0. Otherwise the write has no effect.
- R10: A write of zero to word 5 releases the mutex only when `req_id` equals the current owner. Otherwise the write has no effect.
- R11: From word 6, the vendor, library, component-name and version strings are packed in that order. Each string keeps its characters without its leading zero bytes and is followed by one null byte. Bytes fill each word from bits 31:24 downward. The rest of the identification area is zero. The area is ceil(4*(STR_LEN+1)/4) words long.
- R12: The extra-information string starts at the first word after the identification area (word 15 for STR_LEN 8). It has the same packing and is zero-filled. With EXTRA at zero, the whole area reads zero.
- R13: Reads of words beyond the extra area return zero. Writes to read-only words (0, 1, 2, 4 and the text areas) change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| req_valid | input | 1 | Request taken on this edge |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Word address inside the bank |
| req_id | input | IDW | ID of the requesting master |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read result valid this cycle |
| rd_data | output | 32 | Read result, zero when not valid |
| parent_rst | output | 1 | Active-high software reset to the parent IP |

## Verification
Every read result is due one cycle after its request edge. The bench drives each request at a falling edge and samples `rd_valid` and `rd_data` at the next falling edge, so exactly one rising edge lies between them. Register writes are observed the same way: the effect on `parent_rst` or on the mutex is sampled at the falling edge after the write edge, or through a later read. The back-to-back header test holds the request for two edges and checks one alternating result per falling edge, then checks that `rd_valid` drops one cycle after the request ends.

// File: rtl/iinfo_pkg.sv
package iinfo_pkg;
  localparam int OFS_HDR  = 0;
  localparam int OFS_TYPE = 1;
  localparam int OFS_PTR  = 2;
  localparam int OFS_PRST = 3;
  localparam int OFS_INST = 4;
  localparam int OFS_MTX  = 5;
  localparam int OFS_TEXT = 6;

  localparam logic [31:0] HDR_FWD = 32'h49495231;
  localparam logic [31:0] HDR_REV = 32'h31524949;

  function automatic int words_for(input int nbytes);
    return (nbytes + 3) / 4;
  endfunction
endpackage

// File: rtl/iinfo_hdr.sv
module iinfo_hdr
  import iinfo_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        rd_hit,
  output logic [31:0] word
);
  logic phase;

  always_ff @(posedge clk) begin
    if (rst)         phase <= 1'b0;
    else if (rd_hit) phase <= ~phase;
  end

  assign word = phase ? HDR_REV : HDR_FWD;

  assert_hdr_hold_R3: assert property (@(posedge clk) disable iff (rst)
    !rd_hit |=> $stable(phase));
  assert_hdr_flip_R3: assert property (@(posedge clk) disable iff (rst)
    rd_hit |=> (phase != $past(phase)));
endmodule

// File: rtl/iinfo_mutex.sv
module iinfo_mutex #(
  parameter int IDW = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_hit,
  input  logic [IDW-1:0] wr_id,
  input  logic [IDW-1:0] wr_val,
  output logic [IDW-1:0] owner
);
  logic free_now;
  assign free_now = (owner == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      owner <= '0;
    end else if (wr_hit) begin
      if (wr_val != '0) begin
        if (free_now) owner <= wr_val;
      end else if (wr_id == owner) begin
        owner <= '0;
      end
    end
  end

  assert_mtx_keep_R9: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && owner != '0 && wr_val != '0) |=> $stable(owner));
  assert_mtx_rel_R10: assert property (@(posedge clk) disable iff (rst)
    (wr_hit && wr_val == '0 && wr_id != owner) |=> $stable(owner));
  assert_mtx_idle_R9: assert property (@(posedge clk) disable iff (rst)
    !wr_hit |=> $stable(owner));
endmodule

// File: rtl/iinfo_text.sv
module iinfo_text
  import iinfo_pkg::*;
#(
  parameter int AW      = 6,
  parameter int STR_LEN = 8,
  parameter logic [8*STR_LEN-1:0] VENDOR   = '0,
  parameter logic [8*STR_LEN-1:0] LIBRARY  = '0,
  parameter logic [8*STR_LEN-1:0] COMPNAME = '0,
  parameter logic [8*STR_LEN-1:0] VERSION  = '0,
  parameter logic [8*STR_LEN-1:0] EXTRA    = '0
) (
  input  logic [AW-1:0] addr,
  output logic          hit,
  output logic [31:0]   word
);
  localparam int ID_WORDS  = words_for(4 * (STR_LEN + 1));
  localparam int EX_WORDS  = words_for(STR_LEN + 1);
  localparam int TXT_WORDS = ID_WORDS + EX_WORDS;

  function automatic logic [32*TXT_WORDS-1:0] build_text();
    logic [32*TXT_WORDS-1:0] v;
    logic [8*STR_LEN-1:0]    s;
    logic [7:0]              b;
    logic                    go;
    int                      p;
    v = '0;
    p = 0;
    for (int k = 0; k < 5; k++) begin
      if (k == 4) p = 4 * ID_WORDS;
      case (k)
        0:       s = VENDOR;
        1:       s = LIBRARY;
        2:       s = COMPNAME;
        3:       s = VERSION;
        default: s = EXTRA;
      endcase
      go = 1'b0;
      for (int i = STR_LEN - 1; i >= 0; i--) begin
        b = s[8*i +: 8];
        if (b != 8'h00) go = 1'b1;
        if (go) begin
          v[32*(p/4) + 8*(3 - (p%4)) +: 8] = b;
          p++;
        end
      end
      p++;
    end
    return v;
  endfunction

  localparam logic [32*TXT_WORDS-1:0] TEXT = build_text();

  logic [AW:0] rel;
  assign rel  = {1'b0, addr} - (AW+1)'(OFS_TEXT);
  assign hit  = (addr >= AW'(OFS_TEXT)) && (rel < (AW+1)'(TXT_WORDS));
  assign word = hit ? TEXT[32*int'(rel) +: 32] : 32'h0;
endmodule

// File: rtl/iinfo_bank.sv
module iinfo_bank
  import iinfo_pkg::*;
#(
  parameter int          AW           = 6,
  parameter int          IDW          = 4,
  parameter int          STR_LEN      = 8,
  parameter bit          IS_EXTERNAL  = 1'b0,
  parameter bit          HAS_REGS     = 1'b1,
  parameter bit          CAN_RESET    = 1'b1,
  parameter logic [31:0] PARENT_OFS   = 32'h0000_0040,
  parameter logic [31:0] PARENT_ADDR  = 32'h8000_1000,
  parameter logic [31:0] INSTANCE_NUM = 32'd3,
  parameter logic [8*STR_LEN-1:0] VENDOR   = {32'h0, "vndr"},
  parameter logic [8*STR_LEN-1:0] LIBRARY  = {40'h0, "lib"},
  parameter logic [8*STR_LEN-1:0] COMPNAME = {32'h0, "ctrl"},
  parameter logic [8*STR_LEN-1:0] VERSION  = {40'h0, "1.0"},
  parameter logic [8*STR_LEN-1:0] EXTRA    = '0
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           req_valid,
  input  logic           req_write,
  input  logic [AW-1:0]  req_addr,
  input  logic [IDW-1:0] req_id,
  input  logic [31:0]    req_wdata,
  output logic           rd_valid,
  output logic [31:0]    rd_data,
  output logic           parent_rst
);
  localparam logic [31:0] TYPE_WORD = {29'b0, CAN_RESET, HAS_REGS, IS_EXTERNAL};
  localparam logic [31:0] PTR_WORD  = !HAS_REGS ? 32'h0 :
                                      (IS_EXTERNAL ? PARENT_ADDR : PARENT_OFS);

  logic           rd_req, wr_req;
  logic [31:0]    hdr_word, txt_word, rd_next;
  logic           txt_hit;
  logic [IDW-1:0] owner;
  logic           unused_wdata;

  assign rd_req       = req_valid && !req_write;
  assign wr_req       = req_valid &&  req_write;
  assign unused_wdata = ^req_wdata[31:IDW];

  iinfo_hdr u_hdr (
    .clk    (clk),
    .rst    (rst),
    .rd_hit (rd_req && req_addr == AW'(OFS_HDR)),
    .word   (hdr_word)
  );

  iinfo_mutex #(.IDW(IDW)) u_mtx (
    .clk    (clk),
    .rst    (rst),
    .wr_hit (wr_req && req_addr == AW'(OFS_MTX)),
    .wr_id  (req_id),
    .wr_val (req_wdata[IDW-1:0]),
    .owner  (owner)
  );

  iinfo_text #(
    .AW(AW), .STR_LEN(STR_LEN), .VENDOR(VENDOR), .LIBRARY(LIBRARY),
    .COMPNAME(COMPNAME), .VERSION(VERSION), .EXTRA(EXTRA)
  ) u_txt (
    .addr (req_addr),
    .hit  (txt_hit),
    .word (txt_word)
  );

  always_comb begin
    rd_next = 32'h0;
    if (txt_hit) begin
      rd_next = txt_word;
    end else begin
      case (int'(req_addr))
        OFS_HDR:  rd_next = hdr_word;
        OFS_TYPE: rd_next = TYPE_WORD;
        OFS_PTR:  rd_next = PTR_WORD;
        OFS_PRST: rd_next = {31'b0, parent_rst};
        OFS_INST: rd_next = INSTANCE_NUM;
        OFS_MTX:  rd_next = {{(32-IDW){1'b0}}, owner};
        default:  rd_next = 32'h0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_valid <= 1'b0;
      rd_data  <= 32'h0;
    end else begin
      rd_valid <= rd_req;
      rd_data  <= rd_req ? rd_next : 32'h0;
    end
  end

  generate
    if (CAN_RESET) begin : g_prst
      always_ff @(posedge clk) begin
        if (rst) parent_rst <= 1'b0;
        else if (wr_req && req_addr == AW'(OFS_PRST)) parent_rst <= req_wdata[0];
      end
    end else begin : g_noprst
      assign parent_rst = 1'b0;
    end
  endgenerate

  assert_rd_due_R2: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> rd_valid);
  assert_rd_idle_R2: assert property (@(posedge clk) disable iff (rst)
    !rd_req |=> (!rd_valid && rd_data == 32'h0));
  assert_prst_hold_R6: assert property (@(posedge clk) disable iff (rst)
    !(wr_req && req_addr == AW'(OFS_PRST)) |=> $stable(parent_rst));
  assert_prst_gate_R7: assert property (@(posedge clk) disable iff (rst)
    !CAN_RESET |-> !parent_rst);
  assert_unmapped_R13: assert property (@(posedge clk) disable iff (rst)
    (rd_req && !txt_hit && req_addr > AW'(OFS_MTX)) |=> rd_data == 32'h0);
endmodule

// File: tb/iinfo_bank_tb_top.sv
module iinfo_bank_tb_top;
  localparam int AW = 6, IDW = 4, NV = 33;

  logic clk = 1'b0, rst = 1'b1;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [AW-1:0] req_addr = '0;
  logic [IDW-1:0] req_id = '0;
  logic [31:0] req_wdata = '0;
  logic rd_valid, rd_valid2, parent_rst, parent_rst2;
  logic [31:0] rd_data, rd_data2;
  int n_chk = 0, n_fail = 0;

  always #4 clk = ~clk;

  iinfo_bank #(.EXTRA({48'h0, "d1"})) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rd_valid(rd_valid), .rd_data(rd_data), .parent_rst(parent_rst));

  iinfo_bank #(.IS_EXTERNAL(1'b1), .CAN_RESET(1'b0), .INSTANCE_NUM(32'd7)) dut2_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_write(req_write),
    .req_addr(req_addr), .req_id(req_id), .req_wdata(req_wdata),
    .rd_valid(rd_valid2), .rd_data(rd_data2), .parent_rst(parent_rst2));

  // op: 1 write, 0 read. Expected values: dut_i (E1) and dut2_i (E2).
  localparam bit          V_WR  [NV] = '{0,0,0,1,0, 0,0,1,0,1, 0,0,0,0,0,
                                         0,0,0,0,0, 0,1,0,1,0, 1,0,1,0,1, 0,1,0};
  localparam int          V_AD  [NV] = '{0,0,1,0,0, 2,4,3,3,3, 3,6,7,8,9,
                                         10,14,15,16,18, 63,4,4,5,5, 5,5,5,5,5, 5,5,5};
  localparam int          V_ID  [NV] = '{0,0,0,0,0, 0,0,0,0,0, 0,0,0,0,0,
                                         0,0,0,0,0, 0,0,0,2,0, 5,0,5,0,2, 0,5,0};
  localparam logic [31:0] V_WD  [NV] = '{0,0,0,32'hFFFF_FFFF,0, 0,0,1,0,0,
                                         0,0,0,0,0, 0,0,0,0,0, 0,32'h55,0,2,0,
                                         5,0,0,0,0, 0,5,0};
  localparam logic [31:0] V_E1  [NV] = '{
    32'h49495231, 32'h31524949, 32'h6, 0, 32'h49495231,   // R3 R3 R4 R13 R3
    32'h40, 32'd3, 0, 32'h1, 0,                           // R5 R8 - R6 -
    0, 32'h766e6472, 32'h006c6962, 32'h00637472, 32'h6c00312e, // R6 R11
    32'h30000000, 0, 32'h64310000, 0, 0,                  // R11 R11 R12 R12 R13
    0, 0, 32'd3, 0, 32'd2,                                // R13 - R13 - R9
    0, 32'd2, 0, 32'd2, 0,                                // - R9 - R10 -
    0, 0, 32'd5};                                         // R10 - R9
  localparam logic [31:0] V_E2  [NV] = '{
    32'h49495231, 32'h31524949, 32'h3, 0, 32'h49495231,
    32'h80001000, 32'd7, 0, 0, 0,                         // R5 R8 - R7 -
    0, 32'h766e6472, 32'h006c6962, 32'h00637472, 32'h6c00312e,
    32'h30000000, 0, 0, 0, 0,                             // R12: EXTRA unused
    0, 0, 32'd7, 0, 32'd2,
    0, 32'd2, 0, 32'd2, 0,
    0, 0, 32'd5};
  localparam int          V_REQ [NV] = '{3,3,4,13,3, 5,8,6,6,6, 6,11,11,11,11,
                                         11,11,12,12,13, 13,13,13,9,9, 9,9,10,10,10,
                                         10,9,9};

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_wr(input int a, input int id, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = AW'(a);
    req_id = IDW'(id); req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input int a, input int id);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = AW'(a); req_id = IDW'(id);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    check("R1 rd_valid at reset", {31'b0, rd_valid}, 0);
    check("R1 parent_rst at reset", {31'b0, parent_rst}, 0);
    rst = 1'b0;
    @(negedge clk);

    for (int k = 0; k < NV; k++) begin
      if (V_WR[k]) begin
        bus_wr(V_AD[k], V_ID[k], V_WD[k]);
      end else begin
        bus_rd(V_AD[k], V_ID[k]);
        check($sformatf("R%0d vec %0d dut_i", V_REQ[k], k), rd_data, V_E1[k]);
        check($sformatf("R%0d vec %0d dut2_i", V_REQ[k], k), rd_data2, V_E2[k]);
        check($sformatf("R2 valid vec %0d", k), {31'b0, rd_valid}, 1);
      end
    end

    // R6 / R7: reset bit seen at the port one cycle after the write
    bus_wr(3, 0, 32'h1);
    check("R6 parent_rst set", {31'b0, parent_rst}, 1);
    check("R7 parent_rst gated", {31'b0, parent_rst2}, 0);
    bus_wr(3, 0, 32'hFFFF_FFFE);
    check("R6 parent_rst cleared", {31'b0, parent_rst}, 0);

    // R2 / R3: back-to-back header reads, header currently at second phase
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = '0;
    @(negedge clk);
    check("R2 burst first valid", {31'b0, rd_valid}, 1);
    check("R3 burst first", rd_data, 32'h31524949);
    @(negedge clk);
    req_valid = 1'b0;
    check("R3 burst second", rd_data, 32'h49495231);
    @(negedge clk);
    check("R2 valid drops", {31'b0, rd_valid}, 0);
    check("R2 data zero idle", rd_data, 0);

    // R1: reset in the middle of activity
    bus_wr(3, 0, 32'h1);
    bus_wr(5, 3, 32'h3);
    bus_rd(0, 0);
    @(negedge clk); rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 parent_rst cleared", {31'b0, parent_rst}, 0);
    check("R1 rd_valid cleared", {31'b0, rd_valid}, 0);
    rst = 1'b0;
    bus_rd(5, 0);
    check("R1 mutex free", rd_data, 0);
    bus_rd(0, 0);
    check("R1 header phase", rd_data, 32'h49495231);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule